// File: doc/BRIEF.md
# Memory Region Access Fault Checker

This block inspects one memory access per request and decides whether it touches a protected or unimplemented address window. Each request carries a 32-bit address, an access kind (data load, data store, read-modify-write, instruction fetch), a size code and a remap-enable bit. The block registers the request and, on the next clock, presents a report. The report holds the address as the access will use it and a 2-bit cause code. A fault flag is raised whenever the cause is not "none".

The window map is fixed. Loads and stores share one pair of windows. In the upper pair, a fault is raised only for 8-byte accesses. Read-modify-write accesses have their own exception windows, and one of these is open while remap is enabled. Instruction fetches are first aligned down to their size. The fetch is then tested against an error window before its exception windows are considered.

Control is a two-state machine. ST_IDLE means no report is shown. ST_REPORT means the registered request is being reported. The transition to ST_REPORT, from either state, is taken whenever req_valid is high at a clock edge. The transition to ST_IDLE, from either state, is taken whenever req_valid is low. Reset forces ST_IDLE.

Top module: `mrf_fault_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rsp_valid, rsp_fault and rsp_cause are all zero, and any request presented during reset produces no report.
- R2: A request accepted at a clock edge with req_valid high is reported with rsp_valid high in exactly the next cycle. Back-to-back requests are reported in consecutive cycles and in order. A cycle with req_valid low produces no report.
- R3: A data load (req_kind 00) at an address from 0xFE800000 to 0xFEFEFFFF reports cause 01 (error), for every size code.
- R4: A data load at an address from 0xFEFF0000 to 0xFEFFFFFF reports cause 01 only when req_size is 3 (8 bytes). Size codes 0, 1 and 2 (1, 2 and 4 bytes) report cause 00.
- R5: A data store (req_kind 01) uses the same windows and size rule as a load, but reports cause 11 (store error).
- R6: A read-modify-write (req_kind 10) at an address from 0xFE000000 to 0xFE3FFFFF, or from 0xFE408000 to 0xFE7FFFFF, reports cause 10 (exception) for any size and alignment.
- R7: A read-modify-write at an address from 0xFE400000 to 0xFE407FFF reports cause 10 when remap_en is 0, and cause 00 when remap_en is 1.
- R8: For an instruction fetch (req_kind 11), rsp_addr is req_addr with its low req_size bits cleared, and every window test uses that aligned address. For all other kinds, rsp_addr equals req_addr unchanged.
- R9: A fetch whose aligned address is from 0xFE800000 to 0xFEFFFFFF reports cause 01. Otherwise, a fetch from 0xFE008000 to 0xFE7FFFFF reports cause 10. A fetch from 0xFE000000 to 0xFE007FFF reports cause 10 only when remap_en is 0.
- R10: An access outside every window that applies to its kind reports cause 00 with rsp_fault low. rsp_fault is high exactly when a report carries a cause other than 00. Outside a report, rsp_fault and rsp_cause are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe; the request is accepted at the rising edge |
| req_kind | input | 2 | 00 load, 01 store, 10 read-modify-write, 11 instruction fetch |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| remap_en | input | 1 | 1 opens the small remap window to read-modify-write and fetch |
| rsp_valid | output | 1 | A report is presented this cycle |
| rsp_fault | output | 1 | The reported access faults |
| rsp_cause | output | 2 | 00 none, 01 error, 10 exception, 11 store error |
| rsp_addr | output | 32 | The address the access uses; aligned for fetches |

## Verification
The report of one access and the capture of the next can fall in the same cycle. This is the ST_REPORT to ST_REPORT transition. The bench provokes it by issuing back-to-back requests of different kinds, with faulting and clean results alternating. For example, a store error is followed directly by a clean load, and a fetch exception by a remap-gated fetch. A scoreboard queue then judges each report against its own request and in order. A cycle without a request, or a missing or extra report, shows up as a mismatch between rsp_valid and the queue contents.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

    localparam int ADDR_W = 32;
    localparam int SIZE_W = 2;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'b00,
        KIND_STORE = 2'b01,
        KIND_RMW   = 2'b10,
        KIND_FETCH = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_ERROR  = 2'b01,
        CAUSE_EXCEPT = 2'b10,
        CAUSE_STORE  = 2'b11
    } cause_e;

    typedef struct packed {
        acc_kind_e           kind;
        logic [ADDR_W-1:0]   addr;
        logic [SIZE_W-1:0]   size_lg;
        logic                remap_en;
    } acc_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } win_t;

    // Window indices, used by the classifier
    localparam int WI_DATA_ERR   = 0;
    localparam int WI_DATA_WIDE  = 1;
    localparam int WI_RMW_LOW    = 2;
    localparam int WI_RMW_HIGH   = 3;
    localparam int WI_RMW_REMAP  = 4;
    localparam int WI_IF_ERR     = 5;
    localparam int WI_IF_EXC     = 6;
    localparam int WI_IF_REMAP   = 7;
    localparam int NUM_WIN       = 8;

    localparam win_t WIN_TABLE [NUM_WIN] = '{
        '{32'hFE80_0000, 32'hFEFE_FFFF},
        '{32'hFEFF_0000, 32'hFEFF_FFFF},
        '{32'hFE00_0000, 32'hFE3F_FFFF},
        '{32'hFE40_8000, 32'hFE7F_FFFF},
        '{32'hFE40_0000, 32'hFE40_7FFF},
        '{32'hFE80_0000, 32'hFEFF_FFFF},
        '{32'hFE00_8000, 32'hFE7F_FFFF},
        '{32'hFE00_0000, 32'hFE00_7FFF}
    };

endpackage

// File: rtl/mrf_align.sv
module mrf_align
    import mrf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SIZE_W
) (
    input  logic [AW-1:0] addr_in,
    input  logic [SW-1:0] size_lg,
    input  logic          is_fetch,
    output logic [AW-1:0] addr_out
);

    logic [AW-1:0] keep_mask;

    always_comb begin
        keep_mask = {AW{1'b1}} << size_lg;
        addr_out  = is_fetch ? (addr_in & keep_mask) : addr_in;
    end

endmodule

// File: rtl/mrf_classify.sv
module mrf_classify
    import mrf_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int SW      = SIZE_W,
    parameter int WIDE_LG = 2
) (
    input  acc_kind_e     kind,
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size_lg,
    input  logic          remap_en,
    output cause_e        cause
);

    localparam logic [SW-1:0] WIDE_CODE = SW'(WIDE_LG);

    logic [NUM_WIN-1:0] hit;
    logic               wide;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        assign hit[i] = (addr >= WIN_TABLE[i].lo) && (addr <= WIN_TABLE[i].hi);
    end

    assign wide = size_lg > WIDE_CODE;

    always_comb begin
        cause = CAUSE_NONE;
        unique case (kind)
            KIND_LOAD, KIND_STORE: begin
                if (hit[WI_DATA_ERR] || (hit[WI_DATA_WIDE] && wide))
                    cause = (kind == KIND_STORE) ? CAUSE_STORE : CAUSE_ERROR;
            end
            KIND_RMW: begin
                if (hit[WI_RMW_LOW] || hit[WI_RMW_HIGH] ||
                    (hit[WI_RMW_REMAP] && !remap_en))
                    cause = CAUSE_EXCEPT;
            end
            KIND_FETCH: begin
                if (hit[WI_IF_ERR])
                    cause = CAUSE_ERROR;
                else if (hit[WI_IF_EXC] || (hit[WI_IF_REMAP] && !remap_en))
                    cause = CAUSE_EXCEPT;
            end
            default: cause = CAUSE_NONE;
        endcase
    end

endmodule

// File: rtl/mrf_fault_checker.sv
module mrf_fault_checker
    import mrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic        remap_en,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [1:0]  rsp_cause,
    output logic [31:0] rsp_addr
);

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;

    state_e        state, state_nx;
    acc_req_t      req_q;
    logic [ADDR_W-1:0] addr_al;
    cause_e        cause_w;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_nx = req_valid ? ST_REPORT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            req_q <= '0;
        end else begin
            state <= state_nx;
            if (req_valid) begin
                req_q.kind     <= acc_kind_e'(req_kind);
                req_q.addr     <= req_addr;
                req_q.size_lg  <= req_size;
                req_q.remap_en <= remap_en;
            end
        end
    end

    mrf_align #(.AW(ADDR_W), .SW(SIZE_W)) u_align (
        .addr_in  (req_q.addr),
        .size_lg  (req_q.size_lg),
        .is_fetch (req_q.kind == KIND_FETCH),
        .addr_out (addr_al)
    );

    mrf_classify #(.AW(ADDR_W), .SW(SIZE_W), .WIDE_LG(2)) u_class (
        .kind     (req_q.kind),
        .addr     (addr_al),
        .size_lg  (req_q.size_lg),
        .remap_en (req_q.remap_en),
        .cause    (cause_w)
    );

    always_comb begin
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        rsp_cause = CAUSE_NONE;
        rsp_addr  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_REPORT: begin
                rsp_valid = 1'b1;
                rsp_cause = cause_w;
                rsp_fault = (cause_w != CAUSE_NONE);
                rsp_addr  = addr_al;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mrf_fault_checker_sva.sv
module mrf_fault_checker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic [31:0] req_addr,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [1:0]  rsp_cause,
    input logic [31:0] rsp_addr
);

    // R2
    report_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_report_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_cause == 2'b00));

    // R5
    store_cause_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == 2'b11) |-> $past(req_kind) == 2'b01);

    // R6
    exception_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == 2'b10) |-> $past(req_kind[1]));

    // R8
    data_addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind) != 2'b11) |-> rsp_addr == $past(req_addr));

    // R4
    narrow_top_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind[1]) == 1'b0 && $past(req_addr[31:16]) == 16'hFEFF
         && $past(req_size) != 2'd3) |-> !rsp_fault);

endmodule

bind mrf_fault_checker mrf_fault_checker_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_addr  (rsp_addr)
);

// File: tb/sim_mrf_fault_checker.sv
`timescale 1ns/1ps
module sim_mrf_fault_checker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        remap_en;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_addr;

    always #5 clk = ~clk;

    mrf_fault_checker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_size(req_size), .remap_en(remap_en),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_addr(rsp_addr)
    );

    typedef struct {
        logic [1:0]  cause;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   mon_on = 1'b0;
    bit   done   = 1'b0;

    localparam logic [1:0] LD = 2'b00, ST = 2'b01, RM = 2'b10, IF = 2'b11;

    task automatic issue(input logic [1:0] k, input logic [31:0] a, input logic [1:0] s,
                         input logic rm, input logic [1:0] ec, input logic [31:0] ea,
                         input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = a;
        req_size  = s;
        remap_en  = rm;
        e.cause = ec;
        e.addr  = ea;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_kind  = LD;
            req_addr  = 32'hFE80_0000;
            req_size  = 2'd3;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Monitor: compares each report against the scoreboard
    initial begin
        exp_t e;
        wait (mon_on);
        forever begin
            @(posedge clk);
            #2;
            checks++;
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    fails++;
                    $display("FAIL R2 unexpected report: valid=%b expected=0", rsp_valid);
                end else begin
                    e = sb_q.pop_front();
                    if (rsp_cause !== e.cause || rsp_fault !== (e.cause != 2'b00) ||
                        rsp_addr !== e.addr) begin
                        fails++;
                        $display("FAIL %s cause=%b fault=%b addr=%h expected cause=%b fault=%b addr=%h",
                                 e.tag, rsp_cause, rsp_fault, rsp_addr,
                                 e.cause, (e.cause != 2'b00), e.addr);
                    end
                end
            end else begin
                if (sb_q.size() != 0) begin
                    fails++;
                    $display("FAIL R2 missing report: valid=%b expected=1", rsp_valid);
                end
                if (rsp_fault !== 1'b0 || rsp_cause !== 2'b00) begin
                    fails++;
                    $display("FAIL R10 idle outputs fault=%b cause=%b expected 0/00",
                             rsp_fault, rsp_cause);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: run not finished, expected completion");
            summary();
        end
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b1;
        req_kind  = LD;
        req_addr  = 32'hFE80_0000;
        req_size  = 2'd2;
        remap_en  = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_cause !== 2'b00) begin
            fails++;
            $display("FAIL R1 reset outputs valid=%b fault=%b cause=%b expected 0/0/00",
                     rsp_valid, rsp_fault, rsp_cause);
        end
        req_valid = 1'b0;
        rst_n     = 1'b1;
        mon_on    = 1'b1;
        idle(2);

        // R3 load error window
        issue(LD, 32'hFE80_0000, 2'd2, 0, 2'b01, 32'hFE80_0000, "R3 load low edge");
        issue(LD, 32'hFEFE_FFFF, 2'd0, 0, 2'b01, 32'hFEFE_FFFF, "R3 load high edge");
        issue(LD, 32'hFE7F_FFFF, 2'd2, 0, 2'b00, 32'hFE7F_FFFF, "R10 load below window");
        idle(1);
        // R4 wide-only window
        issue(LD, 32'hFEFF_0000, 2'd2, 0, 2'b00, 32'hFEFF_0000, "R4 load 4B top window");
        issue(LD, 32'hFEFF_0000, 2'd3, 0, 2'b01, 32'hFEFF_0000, "R4 load 8B top window");
        issue(LD, 32'hFEFF_FFF8, 2'd3, 0, 2'b01, 32'hFEFF_FFF8, "R4 load 8B top edge");
        issue(LD, 32'hFF00_0000, 2'd3, 0, 2'b00, 32'hFF00_0000, "R10 load above map");
        // R8 unaligned data address kept
        issue(LD, 32'hFE80_0003, 2'd3, 0, 2'b01, 32'hFE80_0003, "R8 load addr kept");
        // R5 store
        issue(ST, 32'hFE90_0000, 2'd1, 0, 2'b11, 32'hFE90_0000, "R5 store error window");
        issue(LD, 32'h0000_1000, 2'd2, 0, 2'b00, 32'h0000_1000, "R10 clean load after store");
        issue(ST, 32'hFEFF_1000, 2'd2, 0, 2'b00, 32'hFEFF_1000, "R5 store 4B top window");
        issue(ST, 32'hFEFF_1000, 2'd3, 0, 2'b11, 32'hFEFF_1000, "R5 store 8B top window");
        idle(2);
        // R6 / R7 read-modify-write
        issue(RM, 32'hFE00_0000, 2'd2, 0, 2'b10, 32'hFE00_0000, "R6 rmw low window edge");
        issue(RM, 32'hFE3F_FFFF, 2'd3, 1, 2'b10, 32'hFE3F_FFFF, "R6 rmw unaligned, addr kept");
        issue(RM, 32'hFE40_8000, 2'd2, 1, 2'b10, 32'hFE40_8000, "R6 rmw high window edge");
        issue(RM, 32'hFE7F_FFFF, 2'd0, 0, 2'b10, 32'hFE7F_FFFF, "R6 rmw high window end");
        issue(RM, 32'hFE80_0000, 2'd2, 0, 2'b00, 32'hFE80_0000, "R6 rmw outside");
        issue(RM, 32'hFE40_0000, 2'd2, 0, 2'b10, 32'hFE40_0000, "R7 rmw remap off");
        issue(RM, 32'hFE40_7FFF, 2'd2, 1, 2'b00, 32'hFE40_7FFF, "R7 rmw remap on");
        idle(1);
        // R8 / R9 fetch
        issue(IF, 32'hFE80_0002, 2'd2, 0, 2'b01, 32'hFE80_0000, "R9 fetch error aligned");
        issue(IF, 32'hFEFF_FFFF, 2'd3, 0, 2'b01, 32'hFEFF_FFF8, "R9 fetch error top");
        issue(IF, 32'hFE00_8003, 2'd2, 0, 2'b10, 32'hFE00_8000, "R9 fetch exception");
        issue(IF, 32'hFE00_7FFF, 2'd2, 0, 2'b10, 32'hFE00_7FFC, "R9 fetch remap off");
        issue(IF, 32'hFE00_7FFF, 2'd2, 1, 2'b00, 32'hFE00_7FFC, "R9 fetch remap on");
        issue(IF, 32'hFE00_8007, 2'd3, 1, 2'b10, 32'hFE00_8000, "R8 fetch 8B align");
        issue(IF, 32'hFDFF_FFFF, 2'd1, 0, 2'b00, 32'hFDFF_FFFE, "R8 fetch 2B align outside");
        issue(IF, 32'hFE7F_FFFE, 2'd1, 0, 2'b10, 32'hFE7F_FFFE, "R9 fetch exception end");
        idle(3);

        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R2 reports left outstanding=%0d expected 0", sb_q.size());
        end
        done = 1'b1;
        summary();
    end

endmodule